// File: doc/BRIEF.md
# USB Endpoint Pair Control and Handshake Selector

This block keeps the control state of one endpoint pair of a USB device controller and uses it to pick the handshake and data PIDs. A single 32-bit software register holds the state. The transmit (IN) direction occupies byte 2 of the register and the receive (OUT) direction occupies byte 0. Each direction stores an enable, an endpoint type, a stall flag, a test-only toggle inhibit, a data-source bit and a self-clearing toggle-resync bit. The protocol engine reports three events to the block: a received SETUP token, a completed transmit transaction, and a completed receive transaction.

From this state the block tells the engine what to do in each direction. It gives the handshake to return (none, ACK or STALL), the data PID to send on transmit, and the data PID expected on receive. Each direction's data toggle is a two-state machine. Its states are `SEQ_DATA0` and `SEQ_DATA1`. It has three transitions: *advance*, which flips the state after an accepted transaction; *resync*, which goes to `SEQ_DATA0` when software writes the toggle-resync bit; and *hold*, which keeps the current state. A SETUP token updates the stall flags on its own, and the result depends on each direction's type.

Top module: `usb_ep_ctrl`

## Requirements
- R1: After reset the register reads 0x00000000. Both handshake outputs are 00 (none) and both PID outputs are 0 (DATA0).
- R2: Within each direction byte, the bit layout is: bit 7 enable, bit 6 toggle resync, bit 5 toggle inhibit, bit 4 reserved, bits 3:2 type, bit 1 data source, bit 0 stall. The transmit byte sits at bits 23:16 and the receive byte at bits 7:0. Writing all ones reads back 0x00AF00AF: reserved bits and resync bits always read 0.
- R3: The type codes are 00 control, 01 isochronous, 10 bulk and 11 interrupt.
- R4: Each handshake output is 00 (none) when its direction is disabled. It is 10 (STALL) when the direction is enabled and stalled, and 01 (ACK) when enabled and not stalled.
- R5: A SETUP event sets a direction's stall bit when that direction's type is not control, and clears it when the type is control. The type used is the one held before that cycle, and the rule applies whatever the enable bit is.
- R6: When a register write and a SETUP event arrive in the same cycle, the stall bit takes the SETUP result.
- R7: A completion event in a direction that is enabled, not stalled and not isochronous flips that direction's toggle. A PID output of 0 means DATA0 and 1 means DATA1.
- R8: A completion event in a direction that is disabled or stalled leaves that direction's toggle unchanged.
- R9: An isochronous direction reports DATA0 and its toggle does not advance.
- R10: Writing 1 to a resync bit puts that direction's toggle at DATA0 from the next cycle. This takes precedence over a completion event in the same cycle.
- R11: While the transmit inhibit bit is 1, the transmit PID is DATA0, but the toggle keeps advancing underneath. The receive inhibit bit is stored and has no effect on the receive PID.
- R12: The data-source bits are stored and read back, and they have no effect on any handshake or PID output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data |
| setup_evt | input | 1 | SETUP token received |
| tx_done | input | 1 | Transmit transaction completed and acknowledged |
| rx_done | input | 1 | Receive transaction completed and acknowledged |
| tx_hs | output | 2 | Transmit handshake: 00 none, 01 ACK, 10 STALL |
| rx_hs | output | 2 | Receive handshake: 00 none, 01 ACK, 10 STALL |
| tx_pid_data1 | output | 1 | Transmit data PID: 0 DATA0, 1 DATA1 |
| rx_pid_data1 | output | 1 | Expected receive data PID: 0 DATA0, 1 DATA1 |

## Verification
The assertions check the per-direction rules on every cycle:
- the stall result after SETUP,
- SETUP taking precedence over a write,
- resync going to DATA0,
- the toggle advancing only when it should, and holding when the direction is disabled, stalled or isochronous.

Other behaviour only the bench's scenarios can show. This covers the register layout and the read-back of reserved and resync bits. It also covers handshake encodings, the pinning of the transmit PID under inhibit while the toggle runs on, and the lack of any effect from the receive inhibit and data-source bits. A bench reference model follows long random event mixes for these.

// File: rtl/usb_ep_pkg.sv
package usb_ep_pkg;
    localparam int DIR_W      = 8;
    localparam int F_EN       = 7;
    localparam int F_TRST     = 6;
    localparam int F_INH      = 5;
    localparam int F_TYPE_LSB = 2;
    localparam int F_SRC      = 1;
    localparam int F_STALL    = 0;

    typedef enum logic [1:0] {
        EP_CTRL = 2'b00,
        EP_ISO  = 2'b01,
        EP_BULK = 2'b10,
        EP_INTR = 2'b11
    } ep_type_e;

    typedef enum logic [1:0] {
        HS_NONE  = 2'b00,
        HS_ACK   = 2'b01,
        HS_STALL = 2'b10
    } hs_e;

    typedef enum logic {
        SEQ_DATA0 = 1'b0,
        SEQ_DATA1 = 1'b1
    } seq_e;
endpackage

// File: rtl/usb_ep_dir.sv
module usb_ep_dir
    import usb_ep_pkg::*;
#(
    parameter bit IS_TX = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [DIR_W-1:0] wbyte,
    input  logic             setup,
    input  logic             done,
    output logic [DIR_W-1:0] rbyte,
    output logic [1:0]       hs,
    output logic             pid_data1
);
    logic     en_q, inh_q, src_q, stall_q;
    ep_type_e type_q;
    seq_e     seq_q, seq_d;
    logic     tog_clr, adv;

    assign tog_clr = wr && wbyte[F_TRST];
    assign adv     = done && en_q && !stall_q && (type_q != EP_ISO);

    // configuration fields and stall flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q    <= 1'b0;
            inh_q   <= 1'b0;
            src_q   <= 1'b0;
            type_q  <= EP_CTRL;
            stall_q <= 1'b0;
        end else begin
            if (wr) begin
                en_q   <= wbyte[F_EN];
                inh_q  <= wbyte[F_INH];
                src_q  <= wbyte[F_SRC];
                type_q <= ep_type_e'(wbyte[F_TYPE_LSB +: 2]);
            end
            if (setup)
                stall_q <= (type_q != EP_CTRL);
            else if (wr)
                stall_q <= wbyte[F_STALL];
        end
    end

    // toggle state register
    always_ff @(posedge clk) begin
        if (!rst_n) seq_q <= SEQ_DATA0;
        else        seq_q <= seq_d;
    end

    // toggle transitions: resync, advance, hold
    always_comb begin
        seq_d = seq_q;
        unique case (seq_q)
            SEQ_DATA0: if (tog_clr) seq_d = SEQ_DATA0;
                       else if (adv) seq_d = SEQ_DATA1;
            SEQ_DATA1: if (tog_clr) seq_d = SEQ_DATA0;
                       else if (adv) seq_d = SEQ_DATA0;
            default:   seq_d = SEQ_DATA0;
        endcase
    end

    // outputs
    always_comb begin
        rbyte = '0;
        rbyte[F_EN]                 = en_q;
        rbyte[F_INH]                = inh_q;
        rbyte[F_TYPE_LSB +: 2]      = type_q;
        rbyte[F_SRC]                = src_q;
        rbyte[F_STALL]              = stall_q;
        if (!en_q)        hs = HS_NONE;
        else if (stall_q) hs = HS_STALL;
        else              hs = HS_ACK;
    end

    generate
        if (IS_TX) begin : g_tx_pid
            assign pid_data1 = (seq_q == SEQ_DATA1) && !inh_q && (type_q != EP_ISO);
        end else begin : g_rx_pid
            assign pid_data1 = (seq_q == SEQ_DATA1) && (type_q != EP_ISO);
        end
    endgenerate

    assert_setup_stall_R5: assert property (@(posedge clk) disable iff (!rst_n)
        setup |=> (stall_q == $past(type_q != EP_CTRL)));

    assert_setup_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (setup && wr && (wbyte[F_STALL] != (type_q != EP_CTRL))) |=> (stall_q != $past(wbyte[F_STALL])));

    assert_advance_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !tog_clr) |=> (seq_q != $past(seq_q)));

    assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((!en_q || stall_q) && !tog_clr) |=> $stable(seq_q));

    assert_iso_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ((type_q == EP_ISO) && !tog_clr) |=> $stable(seq_q));

    assert_resync_R10: assert property (@(posedge clk) disable iff (!rst_n)
        tog_clr |=> (seq_q == SEQ_DATA0));
endmodule

// File: rtl/usb_ep_ctrl.sv
module usb_ep_ctrl
    import usb_ep_pkg::*;
#(
    parameter int REG_W  = 32,
    parameter int TX_LSB = 16,
    parameter int RX_LSB = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    input  logic             setup_evt,
    input  logic             tx_done,
    input  logic             rx_done,
    output logic [1:0]       tx_hs,
    output logic [1:0]       rx_hs,
    output logic             tx_pid_data1,
    output logic             rx_pid_data1
);
    localparam int NDIR = 2;

    logic [DIR_W-1:0] rbyte_w [NDIR];
    logic [1:0]       hs_w    [NDIR];
    logic [NDIR-1:0]  pid_w;
    logic [NDIR-1:0]  done_w;

    assign done_w = {rx_done, tx_done};

    generate
        for (genvar g = 0; g < NDIR; g++) begin : g_dir
            localparam int LSB = (g == 0) ? TX_LSB : RX_LSB;
            usb_ep_dir #(.IS_TX(g == 0)) u_dir (
                .clk       (clk),
                .rst_n     (rst_n),
                .wr        (reg_wr),
                .wbyte     (reg_wdata[LSB +: DIR_W]),
                .setup     (setup_evt),
                .done      (done_w[g]),
                .rbyte     (rbyte_w[g]),
                .hs        (hs_w[g]),
                .pid_data1 (pid_w[g])
            );
        end
    endgenerate

    always_comb begin
        reg_rdata = '0;
        reg_rdata[TX_LSB +: DIR_W] = rbyte_w[0];
        reg_rdata[RX_LSB +: DIR_W] = rbyte_w[1];
    end

    assign tx_hs        = hs_w[0];
    assign rx_hs        = hs_w[1];
    assign tx_pid_data1 = pid_w[0];
    assign rx_pid_data1 = pid_w[1];
endmodule

// File: tb/usb_ep_ctrl_tb.sv
module usb_ep_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        setup_evt = 1'b0, tx_done = 1'b0, rx_done = 1'b0;
    logic [1:0]  tx_hs, rx_hs;
    logic        tx_pid_data1, rx_pid_data1;

    int errors = 0;
    int checks = 0;

    always #4 clk = ~clk;

    usb_ep_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .setup_evt(setup_evt), .tx_done(tx_done),
        .rx_done(rx_done), .tx_hs(tx_hs), .rx_hs(rx_hs),
        .tx_pid_data1(tx_pid_data1), .rx_pid_data1(rx_pid_data1)
    );

    // reference model, index 0 = transmit, 1 = receive
    logic       m_en [2], m_inh [2], m_src [2], m_stall [2], m_tog [2];
    logic [1:0] m_typ [2];

    function automatic logic [7:0] exp_byte(int d);
        return {m_en[d], 1'b0, m_inh[d], 1'b0, m_typ[d], m_src[d], m_stall[d]};
    endfunction

    function automatic logic [1:0] exp_hs(int d);
        if (!m_en[d])   return 2'b00;
        if (m_stall[d]) return 2'b10;
        return 2'b01;
    endfunction

    function automatic logic exp_pid(int d);
        if (m_typ[d] == 2'b01) return 1'b0;
        if (d == 0 && m_inh[d]) return 1'b0;
        return m_tog[d];
    endfunction

    task automatic model_reset();
        for (int d = 0; d < 2; d++) begin
            m_en[d] = 0; m_inh[d] = 0; m_src[d] = 0; m_stall[d] = 0; m_tog[d] = 0; m_typ[d] = 2'b00;
        end
    endtask

    task automatic model_step(logic wr, logic [31:0] wd, logic su, logic txd, logic rxd);
        for (int d = 0; d < 2; d++) begin
            logic [7:0] b;
            logic dn, n_tog, n_stall;
            b  = (d == 0) ? wd[23:16] : wd[7:0];
            dn = (d == 0) ? txd : rxd;
            n_tog = m_tog[d];
            if (wr && b[6]) n_tog = 1'b0;
            else if (dn && m_en[d] && !m_stall[d] && m_typ[d] != 2'b01) n_tog = ~m_tog[d];
            n_stall = su ? (m_typ[d] != 2'b00) : (wr ? b[0] : m_stall[d]);
            if (wr) begin
                m_en[d] = b[7]; m_inh[d] = b[5]; m_typ[d] = b[3:2]; m_src[d] = b[1];
            end
            m_tog[d] = n_tog; m_stall[d] = n_stall;
        end
    endtask

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic check_all(string req);
        chk(req, "rdata", reg_rdata, {8'h0, exp_byte(0), 8'h0, exp_byte(1)});
        chk(req, "tx_hs", 32'(tx_hs), 32'(exp_hs(0)));
        chk(req, "rx_hs", 32'(rx_hs), 32'(exp_hs(1)));
        chk(req, "tx_pid", 32'(tx_pid_data1), 32'(exp_pid(0)));
        chk(req, "rx_pid", 32'(rx_pid_data1), 32'(exp_pid(1)));
    endtask

    // one clock: drive at negedge, check 1 ns after the posedge
    task automatic cyc(string req, logic wr, logic [31:0] wd, logic su, logic txd, logic rxd);
        reg_wr = wr; reg_wdata = wd; setup_evt = su; tx_done = txd; rx_done = rxd;
        @(posedge clk);
        model_step(wr, wd, su, txd, rxd);
        #1;
        check_all(req);
        @(negedge clk);
        reg_wr = 0; setup_evt = 0; tx_done = 0; rx_done = 0;
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'h00C0FFEE));
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        chk("R1", "rdata", reg_rdata, 32'h0);
        check_all("R1");

        // R2 layout, reserved and resync bits read 0
        cyc("R2", 1, 32'hFFFF_FFFF, 0, 0, 0);
        chk("R2", "all-ones readback", reg_rdata, 32'h00AF_00AF);
        // R12 source bit stored, no effect: enabled bulk with source bit vs without
        cyc("R12", 1, 32'h008A_008A, 0, 0, 0);
        chk("R12", "tx_hs src set", 32'(tx_hs), 32'h1);
        cyc("R7", 0, 0, 0, 1, 1);
        chk("R7", "tx DATA1 after advance", 32'(tx_pid_data1), 32'h1);
        // R3/R9 isochronous: PID DATA0, no advance
        cyc("R9", 1, 32'h0084_0084, 0, 0, 0);
        chk("R9", "iso tx pid", 32'(tx_pid_data1), 32'h0);
        cyc("R9", 0, 0, 0, 1, 1);
        cyc("R3", 1, 32'h0088_0088, 0, 0, 0);
        chk("R9", "toggle held through iso", 32'(tx_pid_data1), 32'h1);
        // R10 resync beats same-cycle completion
        cyc("R10", 1, 32'h00C8_00C8, 0, 1, 1);
        chk("R10", "tx pid after resync", 32'(tx_pid_data1), 32'h0);
        // R4/R8 stalled: STALL handshake, no advance
        cyc("R4", 1, 32'h0089_0089, 0, 0, 0);
        chk("R4", "tx_hs stall", 32'(tx_hs), 32'h2);
        cyc("R8", 0, 0, 0, 1, 1);
        // R8 disabled: no handshake, no advance
        cyc("R8", 1, 32'h0008_0008, 0, 1, 1);
        chk("R4", "rx_hs disabled", 32'(rx_hs), 32'h0);
        // R5 SETUP: tx bulk -> stall, rx control -> clear
        cyc("R5", 1, 32'h0088_0081, 0, 0, 0);
        cyc("R5", 0, 0, 1, 0, 0);
        chk("R5", "stall bits", reg_rdata & 32'h0001_0001, 32'h0001_0000);
        // R6 write clearing tx stall loses to SETUP
        cyc("R6", 1, 32'h0088_0081, 1, 0, 0);
        chk("R6", "stall bits", reg_rdata & 32'h0001_0001, 32'h0001_0000);
        // R11 inhibit pins tx PID, toggle runs on; rx inhibit ignored
        cyc("R11", 1, 32'h00E8_00E8, 0, 0, 0);
        cyc("R11", 1, 32'h00A8_00A8, 0, 1, 1);
        chk("R11", "tx pinned", 32'(tx_pid_data1), 32'h0);
        chk("R11", "rx ignores inhibit", 32'(rx_pid_data1), 32'h1);
        cyc("R11", 1, 32'h0088_0088, 0, 0, 0);
        chk("R11", "tx toggle advanced beneath", 32'(tx_pid_data1), 32'h1);

        // random phase
        for (int i = 0; i < 3000; i++) begin
            logic wr;
            logic [31:0] wd;
            wr = ($urandom % 4) == 0;
            wd = $urandom;
            if (($urandom % 4) != 0) begin
                wd[22] = 1'b0; wd[6] = 1'b0;
            end
            wd[23] = ($urandom % 5) != 0;
            wd[7]  = ($urandom % 5) != 0;
            wd[16] = ($urandom % 3) == 0;
            wd[0]  = ($urandom % 3) == 0;
            cyc("R7", wr, wd, ($urandom % 10) == 0, $urandom % 2, $urandom % 2);
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule